// File: doc/BRIEF.md
# Hysteresis Threshold Programming Unit

This unit holds a falling (low) and a rising (high) threshold, in whole volts, for each of two sensing modes of a discrete-input monitor. A request names a mode, a direction (rising or falling) and a voltage. The unit checks the request against the legal range and the minimum 2 V gap to the opposite threshold. If the new pair would give an odd hysteresis, it moves the opposite threshold by one volt to make the hysteresis even, because the monitored hardware stops working when the hysteresis is odd. It then emits one 16-bit register word for the serial transport to send. The transport itself is outside this unit.

The register word carries the hysteresis (high minus low) in its upper byte and a center code (high plus low, which is the center in half-volt steps) in its lower byte. A separate combinational path decodes any such word back into its rising and falling voltages, so software-visible values can be rebuilt from a word read back from the device.

Results are registered: the outcome of a request sampled on one clock edge appears on the outputs for exactly one cycle after that edge. Requests may arrive on back-to-back cycles, and each one sees the state left by the one before it.

Top module: `hyst_thresh_prog`

## Requirements
- R1: After reset, both modes hold low = 2 and high = 4 (register word 0x0206), and `wr_valid` and `err_pulse` are 0.
- R2: A falling request (`req_rising` = 0) is legal only when 2 <= volts <= 21 and volts + 2 <= the mode's current high threshold.
- R3: A rising request (`req_rising` = 1) is legal only when 3 <= volts <= 22 and volts >= the mode's current low threshold + 2.
- R4: When an accepted falling request leaves high − low odd, the high threshold is lowered by 1.
- R5: When an accepted rising request leaves high − low odd, the low threshold is raised by 1.
- R6: An accepted request emits `wr_word` with high − low in bits 15:8 and high + low in bits 7:0, and `wr_mode` equal to the request's `req_mode`.
- R7: A legal request whose voltage equals the stored threshold of that direction changes nothing and raises neither `wr_valid` nor `err_pulse`.
- R8: An illegal request raises `err_pulse` for one cycle, raises no `wr_valid`, and leaves both thresholds of the mode unchanged.
- R9: Each accepted request produces exactly one `wr_valid` pulse, in the cycle after the clock edge that sampled it. `wr_valid` and `err_pulse` are never high together.
- R10: The decode outputs give `dec_falling` = (bits 7:0 − bits 15:8)/2 and `dec_rising` = (bits 7:0 + bits 15:8)/2 of `dec_word`, combinationally.
- R11: The two modes keep separate thresholds: a request for one mode leaves the other mode's pair unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A request is present this cycle |
| req_rising | input | 1 | 1 = set rising (high) threshold, 0 = set falling (low) threshold |
| req_mode | input | 1 | Sensing mode selected (0 or 1) |
| req_volts | input | 8 | Requested threshold in whole volts |
| wr_valid | output | 1 | One-cycle pulse: a register word is to be written |
| wr_mode | output | 1 | Mode the word belongs to |
| wr_word | output | 16 | {hysteresis, center code} |
| err_pulse | output | 1 | One-cycle pulse: the request was rejected |
| dec_word | input | 16 | Register word to decode |
| dec_rising | output | 8 | Decoded rising threshold, volts |
| dec_falling | output | 8 | Decoded falling threshold, volts |

## Verification
The assertions check on every cycle that each emitted word has an even hysteresis of at least 2 V, and that a write and an error never occur together. They also check that every pulse follows a sampled request, that the mode is echoed, and that the written word decodes back to exactly the requested voltage in the requested direction. Which requests must be rejected, when the opposite threshold moves, that an equal request stays silent, and that a rejected request leaves both the mode's state and the other mode's state untouched can only be shown by the bench. It replays a reference model of both threshold pairs over boundary, odd-gap, back-to-back and cross-mode sequences.

// File: rtl/hyst_pkg.sv
package hyst_pkg;
  // Outcome of one threshold request.
  typedef enum logic [1:0] {
    VERDICT_SILENT = 2'd0,
    VERDICT_WRITE  = 2'd1,
    VERDICT_REJECT = 2'd2
  } verdict_e;
endpackage

// File: rtl/hyst_rst_sync.sv
module hyst_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;
endmodule

// File: rtl/hyst_req_check.sv
module hyst_req_check
  import hyst_pkg::*;
#(
  parameter int VW       = 8,
  parameter int FALL_MIN = 2,
  parameter int FALL_MAX = 21,
  parameter int RISE_MIN = 3,
  parameter int RISE_MAX = 22,
  parameter int MIN_GAP  = 2
) (
  input  logic          rising,
  input  logic [VW-1:0] volts,
  input  logic [VW-1:0] cur_lo,
  input  logic [VW-1:0] cur_hi,
  output verdict_e      verdict,
  output logic [VW-1:0] new_lo,
  output logic [VW-1:0] new_hi
);
  localparam int EW = VW + 1;  // one extra bit so sums never wrap

  logic [EW-1:0] v_x, lo_x, hi_x;
  logic          fall_ok, rise_ok, legal, same;
  logic [VW-1:0] gap;

  assign v_x  = {1'b0, volts};
  assign lo_x = {1'b0, cur_lo};
  assign hi_x = {1'b0, cur_hi};

  assign fall_ok = (v_x >= EW'(FALL_MIN)) && (v_x <= EW'(FALL_MAX)) &&
                   ((v_x + EW'(MIN_GAP)) <= hi_x);
  assign rise_ok = (v_x >= EW'(RISE_MIN)) && (v_x <= EW'(RISE_MAX)) &&
                   (v_x >= (lo_x + EW'(MIN_GAP)));
  assign legal   = rising ? rise_ok : fall_ok;
  assign same    = rising ? (volts == cur_hi) : (volts == cur_lo);

  always_comb begin
    new_lo = cur_lo;
    new_hi = cur_hi;
    if (rising) begin
      new_hi = volts;
      gap    = volts - cur_lo;
      if (gap[0]) new_lo = cur_lo + VW'(1);
    end else begin
      new_lo = volts;
      gap    = cur_hi - volts;
      if (gap[0]) new_hi = cur_hi - VW'(1);
    end
  end

  always_comb begin
    if (!legal)     verdict = VERDICT_REJECT;
    else if (same)  verdict = VERDICT_SILENT;
    else            verdict = VERDICT_WRITE;
  end
endmodule

// File: rtl/hyst_mode_bank.sv
module hyst_mode_bank #(
  parameter int VW        = 8,
  parameter int NUM_MODES = 2,
  parameter int RST_LO    = 2,
  parameter int RST_HI    = 4,
  parameter int MW        = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [MW-1:0] sel_mode,
  input  logic [VW-1:0] upd_lo,
  input  logic [VW-1:0] upd_hi,
  output logic [VW-1:0] sel_lo,
  output logic [VW-1:0] sel_hi
);
  logic [VW-1:0] lo_q [NUM_MODES];
  logic [VW-1:0] hi_q [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_mode
    logic load;
    assign load = upd_en && (sel_mode == MW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[g] <= VW'(RST_LO);
        hi_q[g] <= VW'(RST_HI);
      end else if (load) begin
        lo_q[g] <= upd_lo;
        hi_q[g] <= upd_hi;
      end
    end
  end

  always_comb begin
    sel_lo = lo_q[0];
    sel_hi = hi_q[0];
    for (int m = 1; m < NUM_MODES; m++) begin
      if (sel_mode == MW'(m)) begin
        sel_lo = lo_q[m];
        sel_hi = hi_q[m];
      end
    end
  end
endmodule

// File: rtl/hyst_word_codec.sv
module hyst_word_codec #(
  parameter int VW = 8,
  parameter int WW = 2 * VW
) (
  input  logic [VW-1:0] enc_lo,
  input  logic [VW-1:0] enc_hi,
  output logic [WW-1:0] enc_word,
  input  logic [WW-1:0] dec_word,
  output logic [VW-1:0] dec_rising,
  output logic [VW-1:0] dec_falling
);
  logic [VW:0] dec_sum, dec_diff;

  // upper field: hysteresis, lower field: center code in half-volt steps
  assign enc_word = {enc_hi - enc_lo, enc_hi + enc_lo};

  assign dec_sum     = {1'b0, dec_word[VW-1:0]} + {1'b0, dec_word[WW-1:VW]};
  assign dec_diff    = {1'b0, dec_word[VW-1:0]} - {1'b0, dec_word[WW-1:VW]};
  assign dec_rising  = dec_sum[VW:1];
  assign dec_falling = dec_diff[VW:1];
endmodule

// File: rtl/hyst_thresh_prog.sv
module hyst_thresh_prog
  import hyst_pkg::*;
#(
  parameter int VW        = 8,
  parameter int NUM_MODES = 2,
  parameter int FALL_MIN  = 2,
  parameter int FALL_MAX  = 21,
  parameter int RISE_MIN  = 3,
  parameter int RISE_MAX  = 22,
  parameter int MIN_GAP   = 2,
  parameter int RST_LO    = 2,
  parameter int RST_HI    = 4,
  parameter int MW        = (NUM_MODES > 1) ? $clog2(NUM_MODES) : 1,
  parameter int WW        = 2 * VW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_rising,
  input  logic [MW-1:0] req_mode,
  input  logic [VW-1:0] req_volts,
  output logic          wr_valid,
  output logic [MW-1:0] wr_mode,
  output logic [WW-1:0] wr_word,
  output logic          err_pulse,
  input  logic [WW-1:0] dec_word,
  output logic [VW-1:0] dec_rising,
  output logic [VW-1:0] dec_falling
);
  logic          rst_sync_n;
  logic [VW-1:0] cur_lo, cur_hi, nxt_lo, nxt_hi;
  verdict_e      verdict;
  logic [WW-1:0] word_c;
  logic          accept;

  logic          wr_valid_q, wr_valid_d;
  logic          err_q, err_d;
  logic [MW-1:0] wr_mode_q;
  logic [WW-1:0] wr_word_q;

  hyst_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  hyst_mode_bank #(
    .VW(VW), .NUM_MODES(NUM_MODES), .RST_LO(RST_LO), .RST_HI(RST_HI), .MW(MW)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .upd_en   (accept),
    .sel_mode (req_mode),
    .upd_lo   (nxt_lo),
    .upd_hi   (nxt_hi),
    .sel_lo   (cur_lo),
    .sel_hi   (cur_hi)
  );

  hyst_req_check #(
    .VW(VW), .FALL_MIN(FALL_MIN), .FALL_MAX(FALL_MAX),
    .RISE_MIN(RISE_MIN), .RISE_MAX(RISE_MAX), .MIN_GAP(MIN_GAP)
  ) u_check (
    .rising  (req_rising),
    .volts   (req_volts),
    .cur_lo  (cur_lo),
    .cur_hi  (cur_hi),
    .verdict (verdict),
    .new_lo  (nxt_lo),
    .new_hi  (nxt_hi)
  );

  hyst_word_codec #(.VW(VW), .WW(WW)) u_codec (
    .enc_lo      (nxt_lo),
    .enc_hi      (nxt_hi),
    .enc_word    (word_c),
    .dec_word    (dec_word),
    .dec_rising  (dec_rising),
    .dec_falling (dec_falling)
  );

  // next-state
  always_comb begin
    accept     = req_valid && (verdict == VERDICT_WRITE);
    wr_valid_d = accept;
    err_d      = req_valid && (verdict == VERDICT_REJECT);
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wr_valid_q <= 1'b0;
      err_q      <= 1'b0;
      wr_mode_q  <= '0;
      wr_word_q  <= '0;
    end else begin
      wr_valid_q <= wr_valid_d;
      err_q      <= err_d;
      if (accept) begin
        wr_mode_q <= req_mode;
        wr_word_q <= word_c;
      end
    end
  end

  assign wr_valid  = wr_valid_q;
  assign err_pulse = err_q;
  assign wr_mode   = wr_mode_q;
  assign wr_word   = wr_word_q;
endmodule

// File: rtl/hyst_thresh_prog_chk.sv
module hyst_thresh_prog_chk #(
  parameter int VW       = 8,
  parameter int MW       = 1,
  parameter int WW       = 2 * VW,
  parameter int FALL_MIN = 2,
  parameter int FALL_MAX = 21,
  parameter int RISE_MIN = 3,
  parameter int RISE_MAX = 22,
  parameter int MIN_GAP  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_rising,
  input logic [MW-1:0] req_mode,
  input logic [VW-1:0] req_volts,
  input logic          wr_valid,
  input logic [MW-1:0] wr_mode,
  input logic [WW-1:0] wr_word,
  input logic          err_pulse
);
  logic [VW:0] w_sum, w_diff;
  logic [VW-1:0] w_hyst;
  assign w_hyst = wr_word[WW-1:VW];
  assign w_sum  = {1'b0, wr_word[VW-1:0]} + {1'b0, w_hyst};
  assign w_diff = {1'b0, wr_word[VW-1:0]} - {1'b0, w_hyst};

  // R9: a write and a rejection never coincide
  assert_no_overlap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && err_pulse));

  // R9: every write pulse follows a sampled request
  assert_write_follows_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> $past(req_valid));

  // R8: every rejection pulse follows a sampled request
  assert_err_follows_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid));

  // R4 / R5: written hysteresis is even and at least the minimum gap
  assert_even_hyst_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (!w_hyst[0] && (w_hyst >= VW'(MIN_GAP))));

  // R6: the mode of a written word is the request's mode
  assert_mode_echo_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_mode == $past(req_mode)));

  // R2: a written falling request decodes back to the requested voltage, in range
  assert_fall_roundtrip_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(req_rising)) |->
      ((w_diff[VW:1] == $past(req_volts)) &&
       ($past(req_volts) >= VW'(FALL_MIN)) && ($past(req_volts) <= VW'(FALL_MAX))));

  // R3: a written rising request decodes back to the requested voltage, in range
  assert_rise_roundtrip_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && $past(req_rising)) |->
      ((w_sum[VW:1] == $past(req_volts)) &&
       ($past(req_volts) >= VW'(RISE_MIN)) && ($past(req_volts) <= VW'(RISE_MAX))));
endmodule

bind hyst_thresh_prog hyst_thresh_prog_chk #(
  .VW(VW), .MW(MW), .WW(WW), .FALL_MIN(FALL_MIN), .FALL_MAX(FALL_MAX),
  .RISE_MIN(RISE_MIN), .RISE_MAX(RISE_MAX), .MIN_GAP(MIN_GAP)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .req_valid  (req_valid),
  .req_rising (req_rising),
  .req_mode   (req_mode),
  .req_volts  (req_volts),
  .wr_valid   (wr_valid),
  .wr_mode    (wr_mode),
  .wr_word    (wr_word),
  .err_pulse  (err_pulse)
);

// File: tb/hyst_thresh_prog_test.sv
module hyst_thresh_prog_test;
  typedef enum int {EXP_SILENT, EXP_WRITE, EXP_REJECT} exp_kind_e;
  typedef struct {
    exp_kind_e kind;
    int        mode;
    int        word;
    string     tag;
  } exp_item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_rising = 1'b0;
  logic [0:0]  req_mode = '0;
  logic [7:0]  req_volts = '0;
  logic        wr_valid, err_pulse;
  logic [0:0]  wr_mode;
  logic [15:0] wr_word;
  logic [15:0] dec_word = '0;
  logic [7:0]  dec_rising, dec_falling;

  int checks = 0;
  int errors = 0;
  int m_lo [2];
  int m_hi [2];
  exp_item_t sb [$];
  bit issued;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  hyst_thresh_prog uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rising(req_rising),
    .req_mode(req_mode), .req_volts(req_volts), .wr_valid(wr_valid),
    .wr_mode(wr_mode), .wr_word(wr_word), .err_pulse(err_pulse),
    .dec_word(dec_word), .dec_rising(dec_rising), .dec_falling(dec_falling)
  );

  // Driver: computes the expected outcome from the reference model and
  // presents the request for one cycle.
  task automatic send(input bit rising, input int mode, input int v, input string tag);
    exp_item_t it;
    bit legal;
    it.mode = mode;
    it.word = 0;
    it.tag  = tag;
    if (rising) legal = (v >= 3) && (v <= 22) && (v >= m_lo[mode] + 2);
    else        legal = (v >= 2) && (v <= 21) && (v + 2 <= m_hi[mode]);
    if (!legal) it.kind = EXP_REJECT;
    else if (rising ? (v == m_hi[mode]) : (v == m_lo[mode])) it.kind = EXP_SILENT;
    else begin
      it.kind = EXP_WRITE;
      if (rising) begin
        m_hi[mode] = v;
        if (((m_hi[mode] - m_lo[mode]) % 2) != 0) m_lo[mode]++;
      end else begin
        m_lo[mode] = v;
        if (((m_hi[mode] - m_lo[mode]) % 2) != 0) m_hi[mode]--;
      end
      it.word = ((m_hi[mode] - m_lo[mode]) << 8) | (m_hi[mode] + m_lo[mode]);
    end
    sb.push_back(it);
    @(negedge clk);
    req_valid  = 1'b1;
    req_rising = rising;
    req_mode   = 1'(mode);
    req_volts  = 8'(v);
    @(negedge clk);
    req_valid  = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check_decode(input int word, input int exp_r, input int exp_f);
    dec_word = 16'(word);
    #1;
    checks++;
    if (dec_rising !== 8'(exp_r) || dec_falling !== 8'(exp_f)) begin
      errors++;
      $display("FAIL R10 decode %h: rising=%0d falling=%0d expected rising=%0d falling=%0d",
               word, dec_rising, dec_falling, exp_r, exp_f);
    end
  endtask

  // Monitor: pops one expected item per sampled request and compares.
  always @(posedge clk) begin
    issued = req_valid && rst_n;
    #1;
    if (issued) begin
      exp_item_t e;
      bit ok;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9 result with no expected item: wr_valid=%b err=%b expected none",
                 wr_valid, err_pulse);
      end else begin
        e = sb.pop_front();
        case (e.kind)
          EXP_WRITE:  ok = (wr_valid === 1'b1) && (err_pulse === 1'b0) &&
                           (int'(wr_mode) == e.mode) && (int'(wr_word) == e.word);
          EXP_REJECT: ok = (wr_valid === 1'b0) && (err_pulse === 1'b1);
          default:    ok = (wr_valid === 1'b0) && (err_pulse === 1'b0);
        endcase
        if (!ok) begin
          errors++;
          $display("FAIL %s: wr_valid=%b err=%b mode=%0d word=%h expected kind=%0d mode=%0d word=%h",
                   e.tag, wr_valid, err_pulse, wr_mode, wr_word, e.kind, e.mode, e.word[15:0]);
        end
      end
    end else if (rst_n && (wr_valid !== 1'b0 || err_pulse !== 1'b0)) begin
      checks++;
      errors++;
      $display("FAIL R9 spurious pulse: wr_valid=%b err=%b expected 0 0", wr_valid, err_pulse);
    end
  end

  initial begin
    fork
      begin
        #400000;
        if (!done) begin
          checks++;
          errors++;
          $display("FAIL watchdog expired: done=0 expected 1");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none

    m_lo[0] = 2; m_hi[0] = 4; m_lo[1] = 2; m_hi[1] = 4;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1: reset outputs
    checks++;
    if (wr_valid !== 1'b0 || err_pulse !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset outputs: wr_valid=%b err=%b expected 0 0", wr_valid, err_pulse);
    end
    check_decode(16'h0206, 4, 2);  // R1 reset word decodes to lo=2 hi=4

    // R1 / R7: reset values equal to requests -> silent
    send(1'b0, 0, 2, "R7 falling equal to reset low");
    send(1'b1, 0, 4, "R7 rising equal to reset high");
    // R6: even gap, plain write
    send(1'b1, 0, 10, "R6 rising to 10");
    // R5: odd gap raises low
    send(1'b1, 0, 7, "R5 rising odd gap");
    // R4: odd gap lowers high
    send(1'b0, 0, 4, "R4 falling odd gap");
    // R2 rejections
    send(1'b0, 0, 5, "R2 falling gap too small");
    send(1'b0, 0, 1, "R2 falling below range");
    send(1'b0, 0, 22, "R2 falling above range");
    // R3 rejections
    send(1'b1, 0, 5, "R3 rising gap too small");
    send(1'b1, 0, 23, "R3 rising above range");
    send(1'b1, 0, 2, "R3 rising below range");
    // R8: state unchanged after rejections
    send(1'b1, 0, 8, "R8 state kept after rejects");
    // R11: mode 1 untouched by mode 0 traffic
    send(1'b0, 1, 2, "R11 mode 1 still at reset low");
    send(1'b1, 1, 22, "R3 rising at top of range");
    send(1'b0, 1, 21, "R2 falling 21 exceeds gap");
    send(1'b0, 1, 20, "R2 falling at minimum gap");
    send(1'b0, 0, 4, "R11 mode 0 low kept");
    send(1'b0, 0, 6, "R2 falling at minimum gap mode 0");
    idle(4);

    // R9: nothing left pending
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 pending items: %0d expected 0", sb.size());
    end

    // R10 decode patterns
    check_decode(16'h040A, 7, 3);
    check_decode(16'h1418, 22, 2);
    check_decode(16'h022A, 22, 20);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule